// File: doc/BRIEF.md
# Direction-Configurable Dual Byte FIFO

This block holds two independent byte queues, each four entries deep, sitting between a host bus and an internal datapath. Every queue has its own direction bit. With the bit low the queue works as an input buffer: the host writes it and the datapath drains it. With the bit high it works as an output buffer: the datapath fills it and the host drains it. Strobes arriving from the side that is not active for a queue are ignored.

In output mode each queue captures one of three datapath values (accumulator 0, accumulator 1 or the ALU result), chosen per queue. Two such queues together give a dual-capture arrangement. In input mode the two queues present their head bytes to the datapath, which can load them into its data and accumulator registers (dual-buffer arrangement). Each queue reports its level, empty, full, sticky overflow and sticky underflow. It also drives one selectable flag that can serve as an interrupt or DMA request. A synchronous clear input, or any change of a queue's direction, empties that queue and clears its flags.

Top module: `fifo_pair_bidir`

## Requirements
- R1: After reset both queues are in input mode, level 0, empty high, full low, overflow and underflow low, and both read-data outputs are zero.
- R2: In input mode (direction bit 0) host writes are stored in order. A datapath read strobe puts the oldest byte on that queue's datapath read-data output one cycle later, while its host read-data output reads zero.
- R3: In output mode (direction bit 1) a datapath write stores the value picked by that queue's 2-bit capture select (00 accumulator 0, 01 accumulator 1, 10 or 11 ALU). A host read strobe puts the oldest byte on the host read-data output one cycle later, while the datapath read-data output reads zero.
- R4: Write and read strobes from the inactive side of a queue leave its level and read data unchanged.
- R5: Level counts stored bytes from 0 to 4 (3 bits per queue, queue 0 in the low bits). Empty is high at level 0 and full at level 4, all updated the cycle after the strobe.
- R6: A write to a full queue with no read in the same cycle is dropped and sets that queue's overflow flag, which stays set until clear.
- R7: A read from an empty queue leaves the read data at its previous value and sets that queue's underflow flag, which stays set until clear. A write in the same cycle is still stored.
- R8: A read and a write in the same cycle on a non-empty queue, including a full one, both take effect and leave the level unchanged.
- R9: A clear strobe empties its queue, zeroes its read data and clears its overflow and underflow flags, overriding any strobe in that cycle and leaving the other queue untouched.
- R10: A change of a queue's direction bit empties that queue and clears its flags on that edge, with no effect on the other queue.
- R11: Each queue's 2-bit flag select (queue 0 in bits 1:0) drives its status flag output: 00 empty, 01 full, 10 not empty, 11 overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_i | input | 2 | Direction per queue: 0 input buffer, 1 output buffer |
| clr_i | input | 2 | Synchronous clear per queue |
| bus_wr_i | input | 2 | Host write strobe per queue |
| bus_rd_i | input | 2 | Host read strobe per queue |
| bus_wdata_i | input | 8 | Host write data, shared by both queues |
| dp_wr_i | input | 2 | Datapath write strobe per queue |
| dp_rd_i | input | 2 | Datapath read strobe per queue |
| acc0_i | input | 8 | Datapath accumulator 0 value |
| acc1_i | input | 8 | Datapath accumulator 1 value |
| alu_i | input | 8 | Datapath ALU result |
| cap_sel_i | input | 4 | Capture source select, 2 bits per queue |
| flag_sel_i | input | 4 | Status flag select, 2 bits per queue |
| bus_rdata_o | output | 16 | Host read data, 8 bits per queue |
| dp_rdata_o | output | 16 | Datapath read data, 8 bits per queue |
| level_o | output | 6 | Level, 3 bits per queue |
| empty_o | output | 2 | Empty per queue |
| full_o | output | 2 | Full per queue |
| ovf_o | output | 2 | Sticky overflow per queue |
| unf_o | output | 2 | Sticky underflow per queue |
| flag_o | output | 2 | Selected status flag per queue |

## Verification
On every cycle the assertions check the level bound, dropped writes on a full queue with overflow set, held read data on an empty read with underflow set, the steady level under a simultaneous read and write, the effect of a clear, and the emptying caused by a direction change. Only the bench scenarios can show that bytes leave in the order they entered, that the capture select picks the right datapath value, that inactive-side strobes have no effect, and that each status select routes the intended flag.

// File: rtl/fifo_pair_bidir_pkg.sv
package fifo_pair_bidir_pkg;

   typedef enum logic [1:0] {
      CAP_ACC0 = 2'b00,
      CAP_ACC1 = 2'b01,
      CAP_ALU  = 2'b10,
      CAP_ALUX = 2'b11
   } cap_sel_e;

   typedef enum logic [1:0] {
      FLG_EMPTY = 2'b00,
      FLG_FULL  = 2'b01,
      FLG_AVAIL = 2'b10,
      FLG_ERROR = 2'b11
   } flag_sel_e;

endpackage

// File: rtl/fifo_pair_queue.sv
module fifo_pair_queue #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         wr,
   input  logic                         rd,
   input  logic [DW-1:0]                wdata,
   output logic [DW-1:0]                rdata,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty,
   output logic                         full,
   output logic                         ovf,
   output logic                         unf
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [LW-1:0] count;
   logic          rd_ok, wr_ok;

   assign rd_ok = rd && (count != '0);
   assign wr_ok = wr && ((count != FULL_LVL) || rd_ok);

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!clr && wr_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         rdata  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         rdata  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= bump(wr_ptr);
         if (rd_ok) begin
            rd_ptr <= bump(rd_ptr);
            rdata  <= mem[rd_ptr];
         end
         unique case ({wr_ok, rd_ok})
            2'b10:   count <= count + LW'(1);
            2'b01:   count <= count - LW'(1);
            default: count <= count;
         endcase
         if (wr && !wr_ok) ovf <= 1'b1;
         if (rd && !rd_ok) unf <= 1'b1;
      end
   end

   assign level = count;
   assign empty = (count == '0);
   assign full  = (count == FULL_LVL);

   p_level_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_LVL);

   p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && !clr && count == FULL_LVL) |=> (count == FULL_LVL && ovf));

   p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !clr && count == '0) |=> (unf && $stable(rdata)));

   p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rd && !clr && count != '0) |=> $stable(count));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !ovf && !unf));

endmodule

// File: rtl/fifo_pair_port_mux.sv
module fifo_pair_port_mux
   import fifo_pair_bidir_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          dir,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic          dp_wr,
   input  logic          dp_rd,
   input  logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] acc0,
   input  logic [DW-1:0] acc1,
   input  logic [DW-1:0] alu,
   input  logic [1:0]    cap_sel,
   input  logic [DW-1:0] q_rdata,
   output logic          q_wr,
   output logic          q_rd,
   output logic [DW-1:0] q_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [DW-1:0] dp_rdata
);
   logic [DW-1:0] cap_val;

   always_comb begin
      unique case (cap_sel_e'(cap_sel))
         CAP_ACC0: cap_val = acc0;
         CAP_ACC1: cap_val = acc1;
         default:  cap_val = alu;
      endcase
   end

   assign q_wr      = dir ? dp_wr  : bus_wr;
   assign q_rd      = dir ? bus_rd : dp_rd;
   assign q_wdata   = dir ? cap_val : bus_wdata;
   assign bus_rdata = dir ? q_rdata : '0;
   assign dp_rdata  = dir ? '0 : q_rdata;

endmodule

// File: rtl/fifo_pair_flag_sel.sv
module fifo_pair_flag_sel
   import fifo_pair_bidir_pkg::*;
(
   input  logic       empty,
   input  logic       full,
   input  logic       ovf,
   input  logic       unf,
   input  logic [1:0] sel,
   output logic       flag
);
   always_comb begin
      unique case (flag_sel_e'(sel))
         FLG_EMPTY: flag = empty;
         FLG_FULL:  flag = full;
         FLG_AVAIL: flag = !empty;
         default:   flag = ovf || unf;
      endcase
   end
endmodule

// File: rtl/fifo_pair_bidir.sv
module fifo_pair_bidir #(
   parameter int NQ    = 2,
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NQ-1:0]    dir_i,
   input  logic [NQ-1:0]    clr_i,
   input  logic [NQ-1:0]    bus_wr_i,
   input  logic [NQ-1:0]    bus_rd_i,
   input  logic [DW-1:0]    bus_wdata_i,
   input  logic [NQ-1:0]    dp_wr_i,
   input  logic [NQ-1:0]    dp_rd_i,
   input  logic [DW-1:0]    acc0_i,
   input  logic [DW-1:0]    acc1_i,
   input  logic [DW-1:0]    alu_i,
   input  logic [2*NQ-1:0]  cap_sel_i,
   input  logic [2*NQ-1:0]  flag_sel_i,
   output logic [NQ*DW-1:0] bus_rdata_o,
   output logic [NQ*DW-1:0] dp_rdata_o,
   output logic [NQ*LW-1:0] level_o,
   output logic [NQ-1:0]    empty_o,
   output logic [NQ-1:0]    full_o,
   output logic [NQ-1:0]    ovf_o,
   output logic [NQ-1:0]    unf_o,
   output logic [NQ-1:0]    flag_o
);
   if (NQ < 1 || DW < 1 || DEPTH < 2) begin : g_bad_cfg
      $error("fifo_pair_bidir: NQ>=1, DW>=1, DEPTH>=2 required");
   end

   logic [NQ-1:0] dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= '0;
      else        dir_q <= dir_i;
   end

   for (genvar g = 0; g < NQ; g++) begin : g_q
      logic          q_wr, q_rd, q_clr;
      logic [DW-1:0] q_wdata, q_rdata;

      assign q_clr = clr_i[g] || (dir_i[g] != dir_q[g]);

      fifo_pair_port_mux #(.DW(DW)) u_mux (
         .dir       (dir_i[g]),
         .bus_wr    (bus_wr_i[g]),
         .bus_rd    (bus_rd_i[g]),
         .dp_wr     (dp_wr_i[g]),
         .dp_rd     (dp_rd_i[g]),
         .bus_wdata (bus_wdata_i),
         .acc0      (acc0_i),
         .acc1      (acc1_i),
         .alu       (alu_i),
         .cap_sel   (cap_sel_i[2*g +: 2]),
         .q_rdata   (q_rdata),
         .q_wr      (q_wr),
         .q_rd      (q_rd),
         .q_wdata   (q_wdata),
         .bus_rdata (bus_rdata_o[g*DW +: DW]),
         .dp_rdata  (dp_rdata_o[g*DW +: DW])
      );

      fifo_pair_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (q_clr),
         .wr    (q_wr),
         .rd    (q_rd),
         .wdata (q_wdata),
         .rdata (q_rdata),
         .level (level_o[g*LW +: LW]),
         .empty (empty_o[g]),
         .full  (full_o[g]),
         .ovf   (ovf_o[g]),
         .unf   (unf_o[g])
      );

      fifo_pair_flag_sel u_flag (
         .empty (empty_o[g]),
         .full  (full_o[g]),
         .ovf   (ovf_o[g]),
         .unf   (unf_o[g]),
         .sel   (flag_sel_i[2*g +: 2]),
         .flag  (flag_o[g])
      );

      p_dir_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (dir_i[g] != dir_q[g]) |=> (level_o[g*LW +: LW] == '0 && !ovf_o[g] && !unf_o[g]));
   end

endmodule

// File: tb/fifo_pair_bidir_tb_top.sv
module fifo_pair_bidir_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 2;
   localparam int DW = 8;
   localparam int LW = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic [NQ-1:0] dir_i, clr_i, bus_wr_i, bus_rd_i, dp_wr_i, dp_rd_i;
   logic [DW-1:0] bus_wdata_i, acc0_i, acc1_i, alu_i;
   logic [2*NQ-1:0] cap_sel_i, flag_sel_i;
   logic [NQ*DW-1:0] bus_rdata_o, dp_rdata_o;
   logic [NQ*LW-1:0] level_o;
   logic [NQ-1:0] empty_o, full_o, ovf_o, unf_o, flag_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_pair_bidir dut_i (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .clr_i(clr_i),
      .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
      .dp_wr_i(dp_wr_i), .dp_rd_i(dp_rd_i), .acc0_i(acc0_i), .acc1_i(acc1_i),
      .alu_i(alu_i), .cap_sel_i(cap_sel_i), .flag_sel_i(flag_sel_i),
      .bus_rdata_o(bus_rdata_o), .dp_rdata_o(dp_rdata_o), .level_o(level_o),
      .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o),
      .flag_o(flag_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int lvl(input int q);
      return int'(level_o[q*LW +: LW]);
   endfunction
   function automatic int brd(input int q);
      return int'(bus_rdata_o[q*DW +: DW]);
   endfunction
   function automatic int drd(input int q);
      return int'(dp_rdata_o[q*DW +: DW]);
   endfunction

   task automatic bus_push(input int q, input logic [7:0] d);
      bus_wdata_i = d; bus_wr_i[q] = 1'b1; tick(); bus_wr_i[q] = 1'b0;
   endtask
   task automatic bus_pop(input int q);
      bus_rd_i[q] = 1'b1; tick(); bus_rd_i[q] = 1'b0;
   endtask
   task automatic dp_push(input int q, input logic [1:0] sel);
      cap_sel_i[2*q +: 2] = sel; dp_wr_i[q] = 1'b1; tick(); dp_wr_i[q] = 1'b0;
   endtask
   task automatic dp_pop(input int q);
      dp_rd_i[q] = 1'b1; tick(); dp_rd_i[q] = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "level0", lvl(0), 0);
      check("R1", "level1", lvl(1), 0);
      check("R1", "empty", int'(empty_o), 3);
      check("R1", "full", int'(full_o), 0);
      check("R1", "ovf|unf", int'(ovf_o | unf_o), 0);
      check("R1", "rdata", int'(bus_rdata_o | dp_rdata_o), 0);
      check("R11", "flag sel empty", int'(flag_o), 3);
   endtask

   task automatic t_input_mode();
      bus_push(0, 8'h11); bus_push(0, 8'h22); bus_push(0, 8'h33);
      check("R5", "level after 3 writes", lvl(0), 3);
      check("R5", "empty0 low", int'(empty_o[0]), 0);
      acc0_i = 8'h99; dp_push(0, 2'b00);
      check("R4", "dp write ignored in input mode", lvl(0), 3);
      bus_pop(0);
      check("R4", "bus read ignored in input mode", lvl(0), 3);
      check("R4", "bus rdata after ignored read", brd(0), 0);
      dp_pop(0);
      check("R2", "first datapath read", drd(0), 8'h11);
      check("R2", "host side reads zero", brd(0), 0);
      check("R2", "level after read", lvl(0), 2);
      dp_pop(0);
      check("R2", "second datapath read", drd(0), 8'h22);
   endtask

   task automatic t_overflow_underflow();
      for (int i = 0; i < 4; i++) bus_push(1, 8'hA0 + 8'(i));
      check("R5", "full1 at 4", int'(full_o[1]), 1);
      check("R5", "level1 at 4", lvl(1), 4);
      flag_sel_i[3:2] = 2'b01; #1;
      check("R11", "flag sel full", int'(flag_o[1]), 1);
      bus_push(1, 8'hA4);
      check("R6", "level after dropped write", lvl(1), 4);
      check("R6", "ovf set", int'(ovf_o[1]), 1);
      for (int i = 0; i < 4; i++) begin
         dp_pop(1);
         check("R6", "order, dropped byte absent", drd(1), 8'hA0 + i);
      end
      check("R6", "ovf sticky", int'(ovf_o[1]), 1);
      check("R5", "empty1 after drain", int'(empty_o[1]), 1);
      flag_sel_i[3:2] = 2'b10; #1;
      check("R11", "flag sel avail", int'(flag_o[1]), 0);
      dp_pop(1);
      check("R7", "rdata held on empty read", drd(1), 8'hA3);
      check("R7", "unf set", int'(unf_o[1]), 1);
      flag_sel_i[3:2] = 2'b11; #1;
      check("R11", "flag sel error", int'(flag_o[1]), 1);
   endtask

   task automatic t_clear();
      bus_push(1, 8'hB0);
      bus_wdata_i = 8'hB1; bus_wr_i[1] = 1'b1; clr_i[1] = 1'b1; tick();
      bus_wr_i[1] = 1'b0; clr_i[1] = 1'b0;
      check("R9", "level after clear with write", lvl(1), 0);
      check("R9", "flags cleared", int'(ovf_o[1] | unf_o[1]), 0);
      check("R9", "rdata zeroed", drd(1), 0);
      check("R9", "other queue untouched", lvl(0), 1);
      bus_push(1, 8'hC0);
   endtask

   task automatic t_output_mode();
      dir_i[0] = 1'b1; tick();
      check("R10", "direction change empties queue", lvl(0), 0);
      check("R10", "other queue keeps level", lvl(1), 1);
      acc0_i = 8'h5A; acc1_i = 8'hC3; alu_i = 8'h7E;
      dp_push(0, 2'b00); dp_push(0, 2'b01); dp_push(0, 2'b10);
      check("R3", "level after captures", lvl(0), 3);
      bus_push(0, 8'hEE);
      check("R4", "host write ignored in output mode", lvl(0), 3);
      bus_pop(0);
      check("R3", "capture acc0", brd(0), 8'h5A);
      check("R3", "datapath side reads zero", drd(0), 0);
      bus_pop(0);
      check("R3", "capture acc1", brd(0), 8'hC3);
      bus_pop(0);
      check("R3", "capture alu", brd(0), 8'h7E);
   endtask

   task automatic t_simultaneous();
      alu_i = 8'h01; dp_push(0, 2'b11);
      alu_i = 8'h02; dp_push(0, 2'b10);
      alu_i = 8'h03; dp_wr_i[0] = 1'b1; bus_rd_i[0] = 1'b1; tick();
      dp_wr_i[0] = 1'b0; bus_rd_i[0] = 1'b0;
      check("R8", "level steady on rd+wr", lvl(0), 2);
      check("R8", "read during rd+wr", brd(0), 8'h01);
      alu_i = 8'h04; dp_push(0, 2'b10);
      alu_i = 8'h05; dp_push(0, 2'b10);
      check("R8", "full before rd+wr", int'(full_o[0]), 1);
      alu_i = 8'h06; dp_wr_i[0] = 1'b1; bus_rd_i[0] = 1'b1; tick();
      dp_wr_i[0] = 1'b0; bus_rd_i[0] = 1'b0;
      check("R8", "level steady at full", lvl(0), 4);
      check("R8", "no overflow at full rd+wr", int'(ovf_o[0]), 0);
      check("R8", "read at full", brd(0), 8'h02);
      for (int i = 0; i < 4; i++) begin
         bus_pop(0);
         check("R8", "order after rd+wr", brd(0), 8'h03 + i);
      end
      alu_i = 8'h07; dp_wr_i[0] = 1'b1; bus_rd_i[0] = 1'b1; tick();
      dp_wr_i[0] = 1'b0; bus_rd_i[0] = 1'b0;
      check("R7", "write kept on empty rd+wr", lvl(0), 1);
      check("R7", "unf on empty rd+wr", int'(unf_o[0]), 1);
      check("R7", "rdata held on empty rd+wr", brd(0), 8'h06);
   endtask

   initial begin
      rst_n = 1'b0;
      dir_i = '0; clr_i = '0; bus_wr_i = '0; bus_rd_i = '0;
      dp_wr_i = '0; dp_rd_i = '0; bus_wdata_i = '0;
      acc0_i = '0; acc1_i = '0; alu_i = '0; cap_sel_i = '0; flag_sel_i = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_input_mode();
      t_overflow_underflow();
      t_clear();
      t_output_mode();
      t_simultaneous();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule